// File: doc/BRIEF.md
# Video Interrupt Latch and Mask

This block sits between the event sources of a video controller and the CPU's interrupt input. It takes four single-cycle event pulses: vertical raster match, horizontal raster match, sprite-to-background collision and sprite-to-sprite collision. Each pulse is held in a status latch. Software enables sources through a mask register. The block drives one active-high, level-sensitive interrupt line. The line stays high for as long as any enabled event remains latched.

Software reads the status register to see which events occurred. It acknowledges an event by writing a 1 to that event's bit. The horizontal raster source is an extended source. It can reach the interrupt line only when a separate extended-control enable is set, and that enable is off after reset, so older software never sees this source raise the line. A register select chooses one of three registers. Reads are combinational from the registered state, and writes take effect on the next rising clock edge.

Top module: `vid_irq_ctrl`

## Requirements
- R1: An event pulse sampled at a rising edge sets its status bit after that edge. In the status register (select 0), bit 0 is the vertical raster, bit 1 is the sprite-to-background collision, bit 2 is the sprite-to-sprite collision and bit 4 is the horizontal raster. Bits 3, 5 and 6 read as 0.
- R2: Events are latched into status whatever the mask register holds. The mask gates only the interrupt line.
- R3: A latched status bit keeps its value across cycles with no acknowledge. Writing 0 to a status bit leaves that bit unchanged.
- R4: Writing 1 to a status bit clears that bit at the next edge.
- R5: When an event pulse and a write-1 acknowledge hit the same bit in the same cycle, the bit stays set.
- R6: The mask register (select 1) uses the same bit positions as status and reads back only bits 0, 1, 2 and 4. `irq_o` is high exactly when a latched bit among 0 to 2 has its mask bit set, or when the rule in R7 applies to bit 4.
- R7: Latched horizontal raster status raises `irq_o` only when its mask bit is set and bit 6 of the extended-control register (select 2) is set. The extended-control register reads back only bit 6.
- R8: When the mask register holds 0, `irq_o` is low whatever status holds.
- R9: Status bit 7 reads as the current value of `irq_o`.
- R10: Reset clears status, mask and the extended enable. `irq_o` is low and every register reads 0.
- R11: Select 3 reads 0, and writes to select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_vraster | input | 1 | Vertical raster match pulse |
| evt_spr_bg | input | 1 | Sprite-to-background collision pulse |
| evt_spr_spr | input | 1 | Sprite-to-sprite collision pulse |
| evt_hraster | input | 1 | Horizontal raster match pulse |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 extended control, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
An incoming event and a software acknowledge of the same status bit can land in the same clock cycle. The bench provokes this by driving each event pulse in the same cycle as a status write that has every bit at 1. It judges the result by reading status afterwards: the colliding bit must still be set, and every bit that had no event must be clear. Separately, an exhaustive sweep covers every combination of mask, extended enable and event pattern. For each combination the bench computes the expected status readback and interrupt level arithmetically.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = 2;
    // compact source indices
    localparam int IDX_VR   = 0;
    localparam int IDX_SB   = 1;
    localparam int IDX_SS   = 2;
    localparam int IDX_HR   = 3;
    // register bit positions
    localparam int BIT_IRQ  = 7;
    localparam int BIT_XEN  = 6;
    localparam logic [NUM_SRC-1:0] EXT_SRC = NUM_SRC'(1) << IDX_HR;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_EXT    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               ext_en;
    } ctrl_t;

    function automatic int src_pos(input int idx);
        return (idx == IDX_HR) ? 4 : idx;
    endfunction

    function automatic logic [REG_W-1:0] expand(input logic [NUM_SRC-1:0] c);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) r[src_pos(i)] = c[i];
        return r;
    endfunction
endpackage

// File: rtl/vid_irq_latch.sv
module vid_irq_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] stat_d, stat_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            // event has priority over acknowledge
            stat_d[i] = evt_i[i] | (stat_q[i] & ~ack_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign q_o = stat_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chk
            a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[g] |=> q_o[g]);
            a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_i[g] && !evt_i[g]) |=> !q_o[g]);
            a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!ack_i[g] && !evt_i[g]) |=> $stable(q_o[g]));
        end
    endgenerate
endmodule

// File: rtl/vid_irq_gate.sv
module vid_irq_gate #(
    parameter int N = 4,
    parameter logic [N-1:0] EXT = '0
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    input  logic         ext_en_i,
    output logic         irq_o
);
    logic [N-1:0] allow;

    always_comb begin
        allow = ext_en_i ? {N{1'b1}} : ~EXT;
        irq_o = |(pend_i & mask_i & allow);
    end
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
    import vid_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_vraster,
    input  logic             evt_spr_bg,
    input  logic             evt_spr_spr,
    input  logic             evt_hraster,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_o
);
    logic [NUM_SRC-1:0] evt_vec, wr_cmp, ack_vec, pend;
    ctrl_t              ctrl_d, ctrl_q;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        evt_vec         = '0;
        evt_vec[IDX_VR] = evt_vraster;
        evt_vec[IDX_SB] = evt_spr_bg;
        evt_vec[IDX_SS] = evt_spr_spr;
        evt_vec[IDX_HR] = evt_hraster;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_pick
            localparam int P = src_pos(g);
            assign wr_cmp[g] = wr_data[P];
        end
    endgenerate

    assign ack_vec = (wr_en && sel == SEL_STATUS) ? wr_cmp : '0;

    vid_irq_latch #(.N(NUM_SRC)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_vec),
        .ack_i (ack_vec),
        .q_o   (pend)
    );

    vid_irq_gate #(.N(NUM_SRC), .EXT(EXT_SRC)) u_gate (
        .pend_i   (pend),
        .mask_i   (ctrl_q.mask),
        .ext_en_i (ctrl_q.ext_en),
        .irq_o    (irq_o)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && sel == SEL_MASK) ctrl_d.mask   = wr_cmp;
        if (wr_en && sel == SEL_EXT)  ctrl_d.ext_en = wr_data[BIT_XEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_STATUS: begin
                rd_data          = expand(pend);
                rd_data[BIT_IRQ] = irq_o;
            end
            SEL_MASK:   rd_data = expand(ctrl_q.mask);
            SEL_EXT:    rd_data[BIT_XEN] = ctrl_q.ext_en;
            default:    rd_data = '0;
        endcase
    end

    a_r8_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mask == '0) |-> !irq_o);
    a_r7_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ext_en && ((pend & ctrl_q.mask & ~EXT_SRC) == '0)) |-> !irq_o);
    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en) |=> irq_o);
    a_r9_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STATUS) |-> (rd_data[BIT_IRQ] == irq_o));
    a_r11_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rd_data == '0));
endmodule

// File: tb/vid_irq_ctrl_bench.sv
module vid_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_vraster = 0, evt_spr_bg = 0, evt_spr_spr = 0, evt_hraster = 0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    vid_irq_ctrl u_vid_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .evt_vraster(evt_vraster), .evt_spr_bg(evt_spr_bg),
        .evt_spr_spr(evt_spr_spr), .evt_hraster(evt_hraster),
        .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // 4-bit pattern p: p0 vertical, p1 spr-bg, p2 spr-spr, p3 horizontal -> bit 4
    function automatic logic [7:0] pos(input logic [3:0] p);
        return {3'b000, p[3], 1'b0, p[2:0]};
    endfunction

    function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] m, input logic x);
        return |(st & m & {3'b000, x, 4'b1111});
    endfunction

    task automatic cyc_write(input logic [1:0] s, input logic [7:0] d, input logic [3:0] p);
        @(negedge clk);
        reg_sel = s; wr_en = 1'b1; wr_data = d;
        {evt_hraster, evt_spr_spr, evt_spr_bg, evt_vraster} = p;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        {evt_hraster, evt_spr_bg, evt_spr_spr, evt_vraster} = 4'b0;
    endtask

    task automatic pulse(input logic [3:0] p);
        @(negedge clk);
        {evt_hraster, evt_spr_spr, evt_spr_bg, evt_vraster} = p;
        @(negedge clk);
        {evt_hraster, evt_spr_spr, evt_spr_bg, evt_vraster} = 4'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s; #1; v = rd_data;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R10: reset state
        for (int s = 0; s < 4; s++) begin rd(2'(s), v); chk("R10 reset read", v, 8'h00); end
        chk("R10 reset irq", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;

        // R1/R2/R6/R7/R8/R9 exhaustive sweep
        for (int m = 0; m < 32; m++) begin
            for (int x = 0; x < 2; x++) begin
                logic [7:0] mb;
                mb = pos(4'(m));
                cyc_write(2'd1, mb | 8'h08, 4'b0);
                cyc_write(2'd2, x[0] ? 8'hFF : 8'hBF, 4'b0);
                rd(2'd1, v); chk("R6 mask readback", v, mb);
                rd(2'd2, v); chk("R7 ext readback", v, {1'b0, x[0], 6'b0});
                for (int p = 0; p < 16; p++) begin
                    logic e;
                    cyc_write(2'd0, 8'hFF, 4'b0);
                    pulse(4'(p));
                    e = exp_irq(pos(4'(p)), mb, x[0]);
                    rd(2'd0, v);
                    chk("R1 R2 R9 status", v, pos(4'(p)) | {e, 7'b0});
                    chk("R6 R7 R8 irq", {7'b0, irq_o}, {7'b0, e});
                end
            end
        end

        // R3: hold across idle cycles, and write-0 leaves bits
        cyc_write(2'd1, 8'h17, 4'b0);
        cyc_write(2'd2, 8'h40, 4'b0);
        pulse(4'hF);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R3 hold", v, 8'h97);
        cyc_write(2'd0, 8'h00, 4'b0);
        rd(2'd0, v); chk("R3 write zero", v, 8'h97);

        // R4: partial acknowledge
        cyc_write(2'd0, 8'h05, 4'b0);
        rd(2'd0, v); chk("R4 partial ack", v, 8'h92);
        cyc_write(2'd0, 8'h12, 4'b0);
        rd(2'd0, v); chk("R4 full ack", v, 8'h00);
        chk("R4 irq low", {7'b0, irq_o}, 8'h00);

        // R5: event and ack collide, per source
        for (int b = 0; b < 4; b++) begin
            cyc_write(2'd0, 8'hFF, 4'(1 << b));
            rd(2'd0, v); chk("R5 event wins", v, pos(4'(1 << b)) | 8'h80);
            cyc_write(2'd0, 8'hFF, 4'b0);
        end

        // R11: select 3 reads zero and writes are ignored
        cyc_write(2'd3, 8'hFF, 4'b0);
        rd(2'd3, v); chk("R11 sel3 read", v, 8'h00);
        rd(2'd1, v); chk("R11 mask untouched", v, 8'h17);
        rd(2'd2, v); chk("R11 ext untouched", v, 8'h40);
        rd(2'd0, v); chk("R11 status untouched", v, 8'h00);

        // R10: reset mid-run
        pulse(4'hF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 3; s++) begin rd(2'(s), v); chk("R10 mid reset", v, 8'h00); end
        chk("R10 irq after reset", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule